// File: doc/BRIEF.md
# Iterative DES Encryptor with Chaining and Full Scan

This block encrypts 64-bit blocks with the Data Encryption Standard. It runs one Feistel round per clock and chains blocks in cipher block chaining mode. A start pulse captures a plaintext and a 64-bit key with parity bits. The key is reduced to its 56 effective bits and expanded round by round by an on-chip key schedule. The data is XORed with the chaining value, passed through the initial permutation, and iterated sixteen times. The result is inverse-permuted into an output register, which also holds the chaining value for the next block.

The four datapath registers form one mux-D scan chain of 192 flip-flops: the input block (64), the left half (32), the right half (32) and the output/chaining block (64). While scan enable is high, the chain shifts one bit per clock. The phase controller, the round counter and the key-schedule registers hold their values and are not part of the chain. A scan of the whole chain with scan-out looped back to scan-in therefore resumes the encryption exactly where it stopped.

Top module: `des_cbc_scan_core`

## Requirements
- R1: With the chaining value at zero, `ct` equals the standard DES encryption of `pt` under `key`, with bit 1 of each standard vector at the MSB, e.g. key 133457799BBCDFF1, plaintext 0123456789ABCDEF gives 85E813540F0AB405.
- R2: The least significant bit of each key byte (bit positions 0, 8, …, 56) has no effect on the ciphertext.
- R3: Each block encrypts `pt` XOR chaining value. The chaining value is the previous ciphertext, or `iv` when `iv_load` is high together with an accepted `start`.
- R4: A `start` sampled in idle at clock edge N gives `done` high and a valid `ct` right after edge N+18, if no scan edges intervene.
- R5: After the accepting edge and one further functional edge, the chain holds {plaintext, IP(plaintext XOR chaining value), chaining value}.
- R6: Chain order, MSB first at `scan_out`, is input[63:0], left[31:0], right[31:0], output[63:0]. `scan_in` enters output bit 0, and each scan-enabled edge shifts one position.
- R7: Scan-enabled edges freeze the phase, the round counter and the key schedule. A full 192-edge loopback scan mid-block leaves `ct` unchanged and delays `done` by exactly the number of scan edges.
- R8: `start` is ignored while `busy` is high. The block in progress finishes with its own ciphertext and timing.
- R9: Synchronous reset clears every register, giving `ct`, `done`, `busy` and `scan_out` all zero.
- R10: `done` is a one-cycle pulse, and `ct` holds its value until the next block completes or a scan shifts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block (accepted only when idle) |
| iv_load | input | 1 | With start: load `iv` as chaining value |
| iv | input | 64 | Initialisation vector |
| pt | input | 64 | Plaintext block |
| key | input | 64 | Key with parity bits (parity ignored) |
| scan_en | input | 1 | Shift the scan chain instead of functional capture |
| scan_in | input | 1 | Serial scan data into output bit 0 |
| ct | output | 64 | Ciphertext / chaining value |
| done | output | 1 | One-cycle pulse: `ct` is new |
| busy | output | 1 | A block is in flight |
| scan_out | output | 1 | Serial scan data from input bit 63 |

## Verification
The assertions rely on two input conditions. `start` is pulsed only when the core is idle or may be ignored, and `scan_en` is held for whole chain lengths when the bench expects state to be restored. The stimulus starts random blocks only after `done`. Every mid-block scan shifts exactly 192 edges with `scan_out` fed back into `scan_in`, so any change in the result comes from the design and not from a disturbed chain. The random blocks run from a fixed seed. Directed cases pin down the known-answer vectors, the ignored key parity, a start pulse during a busy block, and the chaining value loaded through scan.

// File: rtl/des_scan_pkg.sv
package des_scan_pkg;

    localparam int BLK_W    = 64;
    localparam int HALF_W   = BLK_W / 2;
    localparam int KEY_W    = 64;
    localparam int CD_W     = 28;
    localparam int SUB_W    = 48;
    localparam int N_ROUNDS = 16;
    localparam int N_SBOX   = 8;
    localparam int CHAIN_W  = 2 * BLK_W + 2 * HALF_W;
    localparam int RND_W    = $clog2(N_ROUNDS + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_ROUND, PH_FIN} phase_t;

    typedef struct packed {
        logic [HALF_W-1:0] l;
        logic [HALF_W-1:0] r;
    } lr_t;

    typedef struct packed {
        logic [CD_W-1:0] c;
        logic [CD_W-1:0] d;
    } cd_t;

    // Position tables use 1-based numbering with position 1 at the MSB.
    localparam int P_TAB [32] = '{16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26,
                                  5, 18, 31, 10, 2, 8, 24, 14, 32, 27, 3, 9,
                                  19, 13, 30, 6, 22, 11, 4, 25};

    localparam int PC2_TAB [48] = '{14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
                                    23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
                                    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
                                    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

    function automatic int ip_src(input int i);
        int row;
        int col;
        row = (i - 1) / 8;
        col = (i - 1) % 8;
        return ((row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4))) - 8 * col;
    endfunction

    function automatic int e_src(input int i);
        int g;
        int j;
        g = (i - 1) / 6;
        j = (i - 1) % 6;
        return ((4 * g + j - 1 + 32) % 32) + 1;
    endfunction

    function automatic int pc1_src(input int i);
        int k;
        k = i - 1;
        if (k < 28) return 57 + k / 8 - 8 * (k % 8);
        k = k - 28;
        if (k < 24) return 63 - k / 8 - 8 * (k % 8);
        return 28 - 8 * (k - 24);
    endfunction

    function automatic int key_shift(input int rnd);
        return (rnd == 1 || rnd == 2 || rnd == 9 || rnd == 16) ? 1 : 2;
    endfunction

    function automatic logic [3:0] sbox(input int n, input logic [5:0] v);
        logic [255:0] tab;
        int idx;
        idx = int'({v[5], v[0], v[4:1]});
        case (n)
            0: tab = 256'hE4D12FB83A6C59070F74E2D1A6CB953841E8D62BFC973A50FC8249175B3EA06D;
            1: tab = 256'hF18E6B34972DC05A3D47F28EC01A69B50E7BA4D158C6932FD8A13F42B67C05E9;
            2: tab = 256'hA09E63F51DC7B428D70934A6285ECBF1D6498F30B12C5AE71AD069874FE3B52C;
            3: tab = 256'h7DE3069A1285BC4FD8B56F03472C1AE9A690CB7DF13E52843F06A1D8945BC72E;
            4: tab = 256'h2C417AB6853FD0E9EB2C47D150FA3986421BAD78F9C5630EB8C71E2D6F09A453;
            5: tab = 256'hC1AF92680D34E75BAF427C9561DE0B389EF528C3704A1DB6432C95FABE17608D;
            6: tab = 256'h4B2EF08D3C975A61D0B7491AE35C2F8614BDC37EAF6805926BD814A7950FE23C;
            default: tab = 256'hD2846FB1A93E50C71FD8A374C56B0E927B419CE206ADF35821E74A8DFC90356B;
        endcase
        return tab[(63 - idx) * 4 +: 4];
    endfunction

    function automatic logic [BLK_W-1:0] ip_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        y = '0;
        for (int i = 1; i <= BLK_W; i++) y[BLK_W - i] = x[BLK_W - ip_src(i)];
        return y;
    endfunction

    function automatic logic [BLK_W-1:0] fp_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        y = '0;
        for (int i = 1; i <= BLK_W; i++) y[BLK_W - ip_src(i)] = x[BLK_W - i];
        return y;
    endfunction

    function automatic logic [2*CD_W-1:0] pc1_perm(input logic [KEY_W-1:0] k);
        logic [2*CD_W-1:0] y;
        y = '0;
        for (int i = 1; i <= 2 * CD_W; i++) y[2*CD_W - i] = k[KEY_W - pc1_src(i)];
        return y;
    endfunction

    function automatic logic [SUB_W-1:0] pc2_perm(input logic [2*CD_W-1:0] cd);
        logic [SUB_W-1:0] y;
        y = '0;
        for (int i = 1; i <= SUB_W; i++) y[SUB_W - i] = cd[2*CD_W - PC2_TAB[i-1]];
        return y;
    endfunction

    function automatic logic [HALF_W-1:0] feistel(input logic [HALF_W-1:0] r,
                                                   input logic [SUB_W-1:0] k);
        logic [SUB_W-1:0]  t;
        logic [HALF_W-1:0] s;
        logic [HALF_W-1:0] y;
        t = '0;
        s = '0;
        y = '0;
        for (int i = 1; i <= SUB_W; i++) t[SUB_W - i] = r[HALF_W - e_src(i)];
        t = t ^ k;
        for (int n = 0; n < N_SBOX; n++) s[HALF_W-1-4*n -: 4] = sbox(n, t[SUB_W-1-6*n -: 6]);
        for (int i = 1; i <= HALF_W; i++) y[HALF_W - i] = s[HALF_W - P_TAB[i-1]];
        return y;
    endfunction

endpackage

// File: rtl/des_ctrl.sv
module des_ctrl
    import des_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_en,
    input  logic             start,
    output phase_t           phase_o,
    output logic [RND_W-1:0] rnd_o,
    output logic             done_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= PH_IDLE;
            rnd_o   <= '0;
            done_o  <= 1'b0;
        end else if (scan_en) begin
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (phase_o)
                PH_IDLE:  if (start) phase_o <= PH_LOAD;
                PH_LOAD: begin
                    phase_o <= PH_ROUND;
                    rnd_o   <= RND_W'(1);
                end
                PH_ROUND: begin
                    if (rnd_o == RND_W'(N_ROUNDS)) begin
                        phase_o <= PH_FIN;
                        rnd_o   <= '0;
                    end else begin
                        rnd_o <= rnd_o + 1'b1;
                    end
                end
                PH_FIN: begin
                    phase_o <= PH_IDLE;
                    done_o  <= 1'b1;
                end
                default: phase_o <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/des_key_sched.sv
module des_key_sched
    import des_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_en,
    input  logic             load,
    input  logic             advance,
    input  logic [RND_W-1:0] rnd,
    input  logic [KEY_W-1:0] key,
    output logic [SUB_W-1:0] subkey
);
    // Key halves sit outside the scan chain.
    cd_t cd_q;
    cd_t cd_rot;

    always_comb begin
        if (key_shift(int'(rnd)) == 1) begin
            cd_rot.c = {cd_q.c[CD_W-2:0], cd_q.c[CD_W-1]};
            cd_rot.d = {cd_q.d[CD_W-2:0], cd_q.d[CD_W-1]};
        end else begin
            cd_rot.c = {cd_q.c[CD_W-3:0], cd_q.c[CD_W-1:CD_W-2]};
            cd_rot.d = {cd_q.d[CD_W-3:0], cd_q.d[CD_W-1:CD_W-2]};
        end
        subkey = pc2_perm(cd_rot);
    end

    always_ff @(posedge clk) begin
        if (rst)              cd_q <= '0;
        else if (!scan_en) begin
            if (load)         cd_q <= cd_t'(pc1_perm(key));
            else if (advance) cd_q <= cd_rot;
        end
    end
endmodule

// File: rtl/des_round_fn.sv
module des_round_fn
    import des_scan_pkg::*;
(
    input  logic [HALF_W-1:0] r_in,
    input  logic [SUB_W-1:0]  subkey,
    output logic [HALF_W-1:0] f_out
);
    always_comb f_out = feistel(r_in, subkey);
endmodule

// File: rtl/des_cbc_scan_core.sv
module des_cbc_scan_core
    import des_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             iv_load,
    input  logic [BLK_W-1:0] iv,
    input  logic [BLK_W-1:0] pt,
    input  logic [KEY_W-1:0] key,
    input  logic             scan_en,
    input  logic             scan_in,
    output logic [BLK_W-1:0] ct,
    output logic             done,
    output logic             busy,
    output logic             scan_out
);
    phase_t            phase;
    logic [RND_W-1:0]  rnd;
    logic              accept;
    logic [SUB_W-1:0]  subkey;
    logic [HALF_W-1:0] f_out;

    // Scan-chain registers: input, halves, output/chaining.
    logic [BLK_W-1:0]  in_q, in_n;
    lr_t               lr_q, lr_n;
    logic [BLK_W-1:0]  out_q, out_n;
    logic [CHAIN_W-1:0] chain_q;

    des_ctrl u_ctrl (
        .clk(clk), .rst(rst), .scan_en(scan_en), .start(start),
        .phase_o(phase), .rnd_o(rnd), .done_o(done)
    );

    assign accept = (phase == PH_IDLE) && start && !scan_en;

    des_key_sched u_ks (
        .clk(clk), .rst(rst), .scan_en(scan_en), .load(accept),
        .advance(phase == PH_ROUND), .rnd(rnd), .key(key), .subkey(subkey)
    );

    des_round_fn u_rf (.r_in(lr_q.r), .subkey(subkey), .f_out(f_out));

    always_comb begin
        in_n  = accept ? pt : in_q;
        out_n = out_q;
        lr_n  = lr_q;
        if (accept && iv_load) out_n = iv;
        unique case (phase)
            PH_LOAD:  lr_n = lr_t'(ip_perm(in_q ^ out_q));
            PH_ROUND: begin
                lr_n.l = lr_q.r;
                lr_n.r = lr_q.l ^ f_out;
            end
            PH_FIN:   out_n = fp_perm({lr_q.r, lr_q.l});
            default:  ;
        endcase
    end

    assign chain_q = {in_q, lr_q, out_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            lr_q  <= '0;
            out_q <= '0;
        end else if (scan_en) begin
            {in_q, lr_q, out_q} <= {chain_q[CHAIN_W-2:0], scan_in};
        end else begin
            in_q  <= in_n;
            lr_q  <= lr_n;
            out_q <= out_n;
        end
    end

    assign ct       = out_q;
    assign busy     = (phase != PH_IDLE);
    assign scan_out = in_q[BLK_W-1];
endmodule

// File: rtl/des_scan_chk.sv
module des_scan_chk
    import des_scan_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             scan_en,
    input logic             done,
    input logic             busy,
    input logic             scan_out,
    input phase_t           phase,
    input logic [RND_W-1:0] rnd,
    input logic [BLK_W-1:0] in_q
);
    p_scan_shift_r6: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (scan_out == $past(in_q[BLK_W-2])));

    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> ($stable(phase) && $stable(rnd)));

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !scan_en) |=> $stable(in_q));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_latency_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(phase) == PH_FIN));

    p_round_range_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ROUND) |-> (rnd >= RND_W'(1) && rnd <= RND_W'(N_ROUNDS)));
endmodule

bind des_cbc_scan_core des_scan_chk u_chk (
    .clk(clk), .rst(rst), .scan_en(scan_en), .done(done), .busy(busy),
    .scan_out(scan_out), .phase(phase), .rnd(rnd), .in_q(in_q)
);

// File: tb/sim_des_cbc_scan_core.sv
module sim_des_cbc_scan_core;
    import des_scan_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, iv_load = 1'b0, scan_en = 1'b0, scan_in = 1'b0;
    logic [63:0] iv = '0, pt = '0, key = '0;
    logic [63:0] ct;
    logic done, busy, scan_out;

    int n_run = 0;
    int n_fail = 0;
    logic [63:0] chain_v = '0;

    always #5 clk = ~clk;

    des_cbc_scan_core u0 (
        .clk(clk), .rst(rst), .start(start), .iv_load(iv_load), .iv(iv), .pt(pt),
        .key(key), .scan_en(scan_en), .scan_in(scan_in), .ct(ct), .done(done),
        .busy(busy), .scan_out(scan_out)
    );

    function automatic logic [63:0] ref_ip(input logic [63:0] x);
        logic [63:0] y = '0;
        for (int i = 1; i <= 64; i++) y[64 - i] = x[64 - ip_src(i)];
        return y;
    endfunction

    function automatic logic [63:0] ref_des(input logic [63:0] p, input logic [63:0] k);
        logic [63:0] x, y;
        logic [55:0] cd;
        logic [27:0] c, d;
        logic [31:0] l, r, s, t;
        logic [47:0] e, sk;
        x = ref_ip(p);
        l = x[63:32];
        r = x[31:0];
        for (int i = 1; i <= 56; i++) cd[56 - i] = k[64 - pc1_src(i)];
        c = cd[55:28];
        d = cd[27:0];
        for (int rd = 1; rd <= 16; rd++) begin
            for (int z = 0; z < key_shift(rd); z++) begin
                c = {c[26:0], c[27]};
                d = {d[26:0], d[27]};
            end
            cd = {c, d};
            for (int i = 1; i <= 48; i++) sk[48 - i] = cd[56 - PC2_TAB[i-1]];
            for (int i = 1; i <= 48; i++) e[48 - i] = r[32 - e_src(i)];
            e = e ^ sk;
            for (int n = 0; n < 8; n++) s[31 - 4*n -: 4] = sbox(n, e[47 - 6*n -: 6]);
            for (int i = 1; i <= 32; i++) t[32 - i] = s[32 - P_TAB[i-1]];
            t = t ^ l;
            l = r;
            r = t;
        end
        x = {r, l};
        y = '0;
        for (int i = 1; i <= 64; i++) y[64 - ip_src(i)] = x[64 - i];
        return y;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [191:0] act,
                       input logic [191:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one block with no scan; checks latency, result and pulse shape.
    task automatic run_block(input logic [63:0] p, input logic [63:0] k, input logic ivl,
                             input logic [63:0] ivv, input logic [63:0] exp, input string req);
        int cnt;
        pt = p; key = k; iv_load = ivl; iv = ivv; start = 1'b1;
        @(negedge clk);
        start = 1'b0; iv_load = 1'b0;
        cnt = 1;
        while (!done && cnt < 200) begin @(negedge clk); cnt++; end
        chk(cnt == 19, "R4 latency", 192'(cnt), 192'(19));
        chk(ct == exp, req, 192'(ct), 192'(exp));
        chain_v = ct;
        @(negedge clk);
        chk(!done && ct == exp, "R10 pulse/hold", {done, ct}, {1'b0, exp});
    endtask

    // Shift the whole chain once, looping scan_out back into scan_in.
    task automatic loop_scan(output logic [191:0] cap);
        cap = '0;
        scan_en = 1'b1;
        for (int k = 0; k < 192; k++) begin
            cap = {cap[190:0], scan_out};
            scan_in = scan_out;
            @(negedge clk);
        end
        scan_en = 1'b0;
    endtask

    initial begin
        #(1_000_000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] k0, p0, v0, e0, p1;
        logic [191:0] cap, pat;
        int cnt;
        void'($urandom(32'd4611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk(ct == 0 && !done && !busy && !scan_out, "R9 reset",
            {done, busy, scan_out, ct}, 192'(0));

        // R1: known-answer vectors, zero chaining value
        k0 = 64'h133457799BBCDFF1;
        run_block(64'h0123456789ABCDEF, k0, 1'b1, 64'h0, 64'h85E813540F0AB405, "R1 kat1");
        run_block(64'h8787878787878787, 64'h0E329232EA6D0D73, 1'b1, 64'h0,
                  64'h0000000000000000, "R1 kat2");
        // R2: parity bits flipped give the same ciphertext
        run_block(64'h0123456789ABCDEF, k0 ^ 64'h0101010101010101, 1'b1, 64'h0,
                  64'h85E813540F0AB405, "R2 parity");
        // R3: chaining without iv_load uses the previous ciphertext
        p0 = 64'h1122334455667788;
        run_block(p0, k0, 1'b0, 64'h0, ref_des(p0 ^ 64'h85E813540F0AB405, k0), "R3 chain");

        // R8: start during a busy block is ignored
        p0 = 64'hA5A5A5A55A5A5A5A; v0 = 64'h0F0F0F0F0F0F0F0F;
        e0 = ref_des(p0 ^ v0, k0);
        pt = p0; key = k0; iv = v0; iv_load = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; iv_load = 1'b0; cnt = 1;
        repeat (4) begin @(negedge clk); cnt++; end
        pt = ~p0; key = ~k0; iv = '0; iv_load = 1'b1; start = 1'b1;
        @(negedge clk); cnt++;
        start = 1'b0; iv_load = 1'b0;
        while (!done && cnt < 200) begin @(negedge clk); cnt++; end
        chk(cnt == 19 && ct == e0, "R8 busy start", {32'(cnt), ct}, {32'd19, e0});
        @(negedge clk);
        chk(!busy, "R8 no second block", 192'(busy), 192'(0));

        // R5/R7: scan after two functional edges, then resume
        p0 = 64'hDEADBEEF01234567; v0 = 64'h7766554433221100;
        pt = p0; key = k0; iv = v0; iv_load = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; iv_load = 1'b0;
        @(negedge clk);
        loop_scan(cap);
        chk(cap == {p0, ref_ip(p0 ^ v0), v0}, "R5 chain after load", cap,
            {p0, ref_ip(p0 ^ v0), v0});
        cnt = 2;
        while (!done && cnt < 200) begin @(negedge clk); cnt++; end
        chk(cnt == 19 && ct == ref_des(p0 ^ v0, k0), "R7 scan resume",
            {32'(cnt), ct}, {32'd19, ref_des(p0 ^ v0, k0)});

        // R7: scan in the middle of the rounds
        p1 = 64'h0BADF00DCAFEF00D; e0 = ref_des(p1 ^ ct, k0);
        pt = p1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cnt = 1;
        repeat (8) begin @(negedge clk); cnt++; end
        loop_scan(cap);
        while (!done && cnt < 200) begin @(negedge clk); cnt++; end
        chk(cnt == 19 && ct == e0, "R7 mid-round scan", {32'(cnt), ct}, {32'd19, e0});
        @(negedge clk);

        // R6: shift a pattern in while idle, observe order at ct and scan_out
        pat = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
        scan_en = 1'b1;
        for (int k = 0; k < 192; k++) begin scan_in = pat[191 - k]; @(negedge clk); end
        scan_en = 1'b0;
        chk(ct == pat[63:0] && scan_out == pat[191], "R6 scan-in order",
            {scan_out, ct}, {pat[191], pat[63:0]});
        loop_scan(cap);
        chk(cap == pat, "R6 scan-out order", cap, pat);
        // R3: chaining value loaded through scan is used by the next block
        p0 = 64'h5555AAAA3333CCCC;
        run_block(p0, k0, 1'b0, 64'h0, ref_des(p0 ^ pat[63:0], k0), "R3 scanned chain");

        // R1/R3: random chained blocks
        for (int b = 0; b < 12; b++) begin
            logic [63:0] rp, rk, rv;
            logic ld;
            rp = {$urandom(), $urandom()};
            rk = {$urandom(), $urandom()};
            rv = {$urandom(), $urandom()};
            ld = (b % 4 == 0);
            e0 = ref_des(rp ^ (ld ? rv : chain_v), rk);
            run_block(rp, rk, ld, rv, e0, ld ? "R1 random iv" : "R3 random chain");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule